// File: doc/BRIEF.md
# Display Layer Pixel Output Stage with Underflow Recovery

This block sits at the end of one layer pipe of a video compositor. Pixels fetched from memory arrive on a valid/ready stream and wait in a 16-entry FIFO. Each time the display side asks for a pixel (`pix_tick`) while the raster position lies inside the layer window, the oldest buffered pixel is presented on the output one cycle later. Raster position, window bounds and the frame start pulse come from outside. The raster timing generator, address generation, scaling and blending belong to other blocks.

When the window needs a pixel and the FIFO is empty, the block declares an underflow. For the rest of that frame it accepts every fetched pixel and throws it away. Each in-window request then receives a programmable background value. The next frame start flushes the FIFO and normal display resumes. An underflow also sets a sticky status bit, which only a clear pulse resets. The interrupt is that status gated by an enable. The pipe has a long path from input to output, about 64 pixel times, so fetching has to begin well ahead of the window. A fetch that starts late is expected to underflow.

Top module: `layer_underflow_guard`

## Requirements
- R1: While a frame is being displayed normally, the FIFO holds up to 16 pixels and `in_ready` is low exactly when 16 are buffered. Pixels leave in arrival order.
- R2: An in-window `pix_tick` with data buffered gives `out_valid`=1 and the oldest pixel on `out_pix` on the next cycle. An in-window pixel is one with win_x0 <= ras_x < win_x1 and win_y0 <= ras_y < win_y1.
- R3: An in-window `pix_tick` with the FIFO empty during normal display is an underflow. On the next cycle `uf_status` is 1, `out_valid` is 1 and `out_pix` equals `bg_pix`.
- R4: After an underflow and until the next frame start, `in_ready` is 1 and accepted pixels are never shown. Every in-window tick yields `bg_pix`.
- R5: `frame_start` empties the FIFO and ends discard. It has priority over a push or tick in the same cycle. The first pixel shown afterwards is the first pixel accepted after the pulse.
- R6: `uf_status` stays 1 until `status_clr` is pulsed. A clear in the same cycle as a new underflow leaves it at 1.
- R7: `irq` is 1 exactly when `uf_status` and `irq_en` are both 1.
- R8: At most one underflow event occurs per frame. Once `uf_status` has been cleared within a frame that already underflowed, it stays 0 for the rest of that frame, even though the FIFO stays empty.
- R9: After the tick for the last window pixel (win_x1-1, win_y1-1) has been served, further ticks produce no output. `in_ready` is 1 and fetched pixels are dropped until the next frame start.
- R10: A tick outside the window produces no output and consumes no pixel.
- R11: After reset, `out_valid`, `uf_status` and `irq` are 0. `in_ready` is 1, and pixels are dropped until the first frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| pix_tick | input | 1 | Display side requests a pixel at the current raster position |
| ras_x | input | CRD_W | Raster column |
| ras_y | input | CRD_W | Raster line |
| win_x0 | input | CRD_W | First window column |
| win_x1 | input | CRD_W | Column just past the window |
| win_y0 | input | CRD_W | First window line |
| win_y1 | input | CRD_W | Line just past the window |
| bg_pix | input | PIX_W | Background value shown during discard |
| in_valid | input | 1 | Fetched pixel valid |
| in_data | input | PIX_W | Fetched pixel |
| in_ready | output | 1 | Block accepts (buffers or drops) the pixel |
| out_valid | output | 1 | Pixel presented to the display side |
| out_pix | output | PIX_W | Presented pixel |
| irq_en | input | 1 | Interrupt enable |
| status_clr | input | 1 | Pulse that clears the underflow status |
| uf_status | output | 1 | Sticky underflow status |
| irq | output | 1 | Underflow interrupt |

## Verification
The bench targets frames whose fetch starts too late, including fetch that never starts. A design that kept showing stale or late data after the underflow would put fetched pixels on `out_pix` where the background belongs. It also targets a clear that lands in the same cycle as the underflow, and clears pulsed while discard continues. A design with the wrong priority, or one that re-arms the event on every empty tick, would leave `uf_status` wrong. Extra ticks are sent at the last window position. A design that does not return to idle would then emit extra pixels. The bench checks the first frame after an underflow: a missing flush shows up as leftover pixels from the failed frame.

// File: rtl/luh_pkg.sv
// Shared types for the layer underflow guard.
// Assumes nothing beyond the standard.
package luh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // window served or no frame yet: drop fetched pixels
        ST_SHOW = 2'd1,   // normal display from the FIFO
        ST_DISC = 2'd2    // after underflow: drop pixels, show background
    } lay_state_t;
endpackage

// File: rtl/luh_fifo.sv
// Synchronous pixel FIFO with a flush that has priority over push and pop.
// Assumes the caller never pushes when full or pops when empty.
module luh_fifo #(
    parameter int PIX_W = 24,
    parameter int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [PIX_W-1:0] wdata,
    input  logic             pop,
    output logic [PIX_W-1:0] rdata,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);
    logic [PIX_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    // Storage write; not reset, since occupancy is tracked by count.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head of queue and fill flags.
    always_comb begin
        rdata = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CNT_W'(DEPTH));
    end
endmodule

// File: rtl/luh_window.sv
// Decodes whether a display request falls in the layer window and whether it
// is the final window pixel. Assumes x0 < x1 and y0 < y1.
module luh_window #(
    parameter int CRD_W = 12
) (
    input  logic             tick,
    input  logic [CRD_W-1:0] x,
    input  logic [CRD_W-1:0] y,
    input  logic [CRD_W-1:0] x0,
    input  logic [CRD_W-1:0] x1,
    input  logic [CRD_W-1:0] y0,
    input  logic [CRD_W-1:0] y1,
    output logic             hit,
    output logic             last
);
    // Window membership and last-pixel match.
    always_comb begin
        hit  = tick && (x >= x0) && (x < x1) && (y >= y0) && (y < y1);
        last = hit && (x == x1 - 1'b1) && (y == y1 - 1'b1);
    end
endmodule

// File: rtl/luh_ctrl.sv
// Frame-level controller: decides push, pop and flush, tracks discard mode
// and holds the sticky underflow status. Assumes frame_start is one cycle.
module luh_ctrl
    import luh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       win_hit,
    input  logic       win_last,
    input  logic       fifo_empty,
    input  logic       fifo_full,
    input  logic       in_valid,
    input  logic       status_clr,
    output lay_state_t state,
    output logic       in_ready,
    output logic       push,
    output logic       pop,
    output logic       show_bg,
    output logic       uf_evt,
    output logic       uf_status
);
    // Handshake and per-cycle actions derived from the current state.
    always_comb begin
        in_ready = (state == ST_SHOW) ? !fifo_full : 1'b1;
        push     = (state == ST_SHOW) && in_valid && !fifo_full && !frame_start;
        pop      = (state == ST_SHOW) && win_hit && !fifo_empty && !frame_start;
        uf_evt   = (state == ST_SHOW) && win_hit && fifo_empty && !frame_start;
        show_bg  = (state == ST_DISC) && win_hit && !frame_start;
    end

    // Frame state sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (frame_start) begin
            state <= ST_SHOW;
        end else if (uf_evt) begin
            state <= ST_DISC;
        end else if (pop && win_last) begin
            state <= ST_IDLE;
        end
    end

    // Sticky status; a new underflow beats a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            uf_status <= 1'b0;
        end else if (uf_evt) begin
            uf_status <= 1'b1;
        end else if (status_clr) begin
            uf_status <= 1'b0;
        end
    end
endmodule

// File: rtl/layer_underflow_guard.sv
// Per-layer pixel output stage: buffers fetched pixels, serves in-window
// display requests, and recovers from underflow by discarding to frame end.
// Assumes window bounds are stable during a frame.
module layer_underflow_guard
    import luh_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int DEPTH = 16,
    parameter int CRD_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             pix_tick,
    input  logic [CRD_W-1:0] ras_x,
    input  logic [CRD_W-1:0] ras_y,
    input  logic [CRD_W-1:0] win_x0,
    input  logic [CRD_W-1:0] win_x1,
    input  logic [CRD_W-1:0] win_y0,
    input  logic [CRD_W-1:0] win_y1,
    input  logic [PIX_W-1:0] bg_pix,
    input  logic             in_valid,
    input  logic [PIX_W-1:0] in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    input  logic             irq_en,
    input  logic             status_clr,
    output logic             uf_status,
    output logic             irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    logic             win_hit;
    logic             win_last;
    logic             fifo_empty;
    logic             fifo_full;
    logic [CNT_W-1:0] fifo_cnt;
    logic [PIX_W-1:0] fifo_head;
    logic             push;
    logic             pop;
    logic             show_bg;
    logic             uf_evt;
    lay_state_t       state;

    luh_window #(.CRD_W(CRD_W)) u_win (
        .tick (pix_tick),
        .x    (ras_x),
        .y    (ras_y),
        .x0   (win_x0),
        .x1   (win_x1),
        .y0   (win_y0),
        .y1   (win_y1),
        .hit  (win_hit),
        .last (win_last)
    );

    luh_fifo #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (frame_start),
        .push  (push),
        .wdata (in_data),
        .pop   (pop),
        .rdata (fifo_head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .count (fifo_cnt)
    );

    luh_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .win_hit     (win_hit),
        .win_last    (win_last),
        .fifo_empty  (fifo_empty),
        .fifo_full   (fifo_full),
        .in_valid    (in_valid),
        .status_clr  (status_clr),
        .state       (state),
        .in_ready    (in_ready),
        .push        (push),
        .pop         (pop),
        .show_bg     (show_bg),
        .uf_evt      (uf_evt),
        .uf_status   (uf_status)
    );

    // Output register: buffered pixel on a pop, background on underflow or discard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= pop || uf_evt || show_bg;
            out_pix   <= pop ? fifo_head : bg_pix;
        end
    end

    // Interrupt gating.
    always_comb begin
        irq = uf_status && irq_en;
    end
endmodule

// File: rtl/luh_chk.sv
// Assertion checker for layer_underflow_guard, attached by bind below.
module luh_chk
    import luh_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             win_hit,
    input lay_state_t       state,
    input logic             uf_evt,
    input logic             uf_status,
    input logic             status_clr,
    input logic             irq,
    input logic             irq_en,
    input logic             out_valid,
    input logic [PIX_W-1:0] out_pix,
    input logic [PIX_W-1:0] bg_pix,
    input logic [CNT_W-1:0] fifo_cnt
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH)); // R1
    AST_UF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> uf_status); // R3
    AST_DISC_BG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISC && win_hit && !frame_start) |=> (out_valid && out_pix == $past(bg_pix))); // R4
    AST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (fifo_cnt == '0 && state == ST_SHOW)); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (uf_status && !status_clr) |=> uf_status); // R6
    AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (uf_status && irq_en)); // R7
    AST_ONCE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DISC) |-> !uf_evt); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> !out_valid); // R9
endmodule

bind layer_underflow_guard luh_chk #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .win_hit     (win_hit),
    .state       (state),
    .uf_evt      (uf_evt),
    .uf_status   (uf_status),
    .status_clr  (status_clr),
    .irq         (irq),
    .irq_en      (irq_en),
    .out_valid   (out_valid),
    .out_pix     (out_pix),
    .bg_pix      (bg_pix),
    .fifo_cnt    (fifo_cnt)
);

// File: tb/sim_layer_underflow_guard.sv
`timescale 1ns/1ps
module sim_layer_underflow_guard;
    localparam int PIX_W = 24;
    localparam int DEPTH = 16;
    localparam int CRD_W = 12;
    localparam int WX0 = 2, WX1 = 10, WY0 = 1, WY1 = 3;
    localparam int LINE_W = 14, LINES = 4;
    localparam logic [PIX_W-1:0] BG = 24'hABCDEF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, pix_tick = 1'b0, in_valid = 1'b0;
    logic [CRD_W-1:0] ras_x = '0, ras_y = '0;
    logic [PIX_W-1:0] in_data = '0;
    logic in_ready, out_valid, uf_status, irq;
    logic [PIX_W-1:0] out_pix;
    logic irq_en = 1'b0, status_clr = 1'b0;

    always #10 clk = ~clk;

    layer_underflow_guard #(.PIX_W(PIX_W), .DEPTH(DEPTH), .CRD_W(CRD_W)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_tick(pix_tick),
        .ras_x(ras_x), .ras_y(ras_y),
        .win_x0(CRD_W'(WX0)), .win_x1(CRD_W'(WX1)), .win_y0(CRD_W'(WY0)), .win_y1(CRD_W'(WY1)),
        .bg_pix(BG), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_pix(out_pix), .irq_en(irq_en), .status_clr(status_clr),
        .uf_status(uf_status), .irq(irq)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;
    // Reference model: 0 idle, 1 show, 2 discard
    int m_st = 0;
    logic [PIX_W-1:0] m_q[$];
    bit m_stat = 0, m_uf_frame = 0, m_after_uf = 0;
    logic [PIX_W-1:0] next_val = 24'h000100;
    int g_delay = 0, g_fprob = 100, g_clr = -1;
    bit g_clr_uf = 0;

    function automatic bit in_win(int x, int y);
        return (x >= WX0) && (x < WX1) && (y >= WY0) && (y < WY1);
    endfunction

    task automatic check(string req, logic [PIX_W-1:0] act, logic [PIX_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One clock: drive at falling edge, predict, check after the rising edge.
    task automatic step(bit fs, bit tk, int x, int y);
        bit hit, last, ev, e_ov, rdy, acc;
        logic [PIX_W-1:0] e_pix;
        string otag;
        frame_start = fs; pix_tick = tk;
        ras_x = CRD_W'(x); ras_y = CRD_W'(y);
        in_valid = (cyc >= g_delay) && ($urandom_range(99) < g_fprob);
        in_data = next_val;
        hit = tk && in_win(x, y);
        last = hit && (x == WX1 - 1) && (y == WY1 - 1);
        rdy = (m_st == 1) ? (m_q.size() < DEPTH) : 1'b1;
        acc = in_valid && rdy;
        ev = 0; e_ov = 0; e_pix = BG; otag = "R10";
        if (fs) begin
            m_q.delete(); m_after_uf = m_uf_frame; m_st = 1; m_uf_frame = 0; otag = "R5";
        end else if (m_st == 1) begin
            if (hit && m_q.size() > 0) begin
                e_ov = 1; e_pix = m_q.pop_front(); otag = m_after_uf ? "R5" : "R2";
                if (last) m_st = 0;
            end else if (hit) begin
                ev = 1; e_ov = 1; m_st = 2; m_uf_frame = 1; otag = "R3";
            end
            if (acc) m_q.push_back(in_data);
        end else if (m_st == 2) begin
            if (hit) begin e_ov = 1; otag = "R4"; end
        end else begin
            otag = "R9";
        end
        if (acc) next_val = next_val + 1'b1;
        status_clr = (cyc == g_clr) || (g_clr_uf && ev);
        m_stat = ev ? 1'b1 : (status_clr ? 1'b0 : m_stat);
        #1;
        check("R1", PIX_W'(in_ready), PIX_W'(rdy));
        @(posedge clk);
        @(negedge clk);
        cyc++;
        check(otag, PIX_W'(out_valid), PIX_W'(e_ov));
        if (e_ov) check(otag, out_pix, e_pix);
        check(ev ? "R6" : (m_uf_frame ? "R8" : "R6"), PIX_W'(uf_status), PIX_W'(m_stat));
        check("R7", PIX_W'(irq), PIX_W'(m_stat && irq_en));
    endtask

    task automatic run_frame(int delay, int fprob, int tprob, int clr_at, bit clr_uf);
        cyc = 0; g_delay = delay; g_fprob = fprob; g_clr = clr_at; g_clr_uf = clr_uf;
        step(1, 0, 0, 0);
        for (int y = 0; y < LINES; y++) begin
            for (int x = 0; x < LINE_W; x++) begin
                while ($urandom_range(99) >= tprob) step(0, 0, x, y);
                step(0, 1, x, y);
            end
        end
        // R9: extra requests at the last window position after it was served
        repeat (4) step(0, 1, WX1 - 1, WY1 - 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        check("R11", PIX_W'(out_valid), '0);
        check("R11", PIX_W'(uf_status), '0);
        check("R11", PIX_W'(irq), '0);
        check("R11", PIX_W'(in_ready), 24'd1);
        rst_n = 1'b1;
        irq_en = 1'b1;
        // R11: pixels before the first frame are dropped
        g_delay = 0; g_fprob = 100;
        repeat (5) step(0, 1, 4, 1);
        // R1/R2: early full fetch, FIFO fills and back-pressures
        run_frame(0, 100, 40, -1, 0);
        // R3/R4/R8: fetch never starts, clear during discard
        run_frame(100000, 0, 70, 40, 0);
        // R5: clean resumption after the failed frame
        run_frame(0, 100, 50, -1, 0);
        // R3/R6: clear collides with the underflow
        run_frame(30, 60, 90, -1, 1);
        irq_en = 1'b0;
        run_frame(20, 50, 90, 5, 0);   // R7 with interrupt disabled
        irq_en = 1'b1;
        for (int f = 0; f < 30; f++) begin
            irq_en = $urandom_range(1);
            run_frame($urandom_range(40), 30 + $urandom_range(70),
                      20 + $urandom_range(80), $urandom_range(80) - 10, $urandom_range(1));
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule